// File: doc/BRIEF.md
# Bridge Mailbox Interrupt Controller

This block sits between the host link side and the local interconnect side of a bus bridge and lets each side signal the other. Each side owns a bank of eight 32-bit mailboxes that only it may write and that both sides may read. Writing a mailbox sets a matching doorbell bit in the status register seen by the other side. Each status register has an enable register, and the interrupt toward a side is the OR of the doorbell bits that are both set and enabled. The side that reads a status register clears a doorbell bit by writing a one to it.

Toward the local side the interrupt is a plain level, `l_irq`. Toward the host link the interrupt takes one of two forms. In message mode it is a one-cycle pulse, `msi_pulse`, given when the host interrupt condition becomes true. In legacy mode it is a level request, `leg_req`, that the link acknowledges each time it changes. The legacy request is suppressed while the command-register interrupt-disable input is set. The host status register also reflects the live level of sixteen local interrupt lines, and each of those lines can be enabled into the host interrupt.

Both register ports are word-addressed. A write is taken on the clock edge while its write enable is high. Read data is a combinational function of the port's address.

Top module: `bmb_mailbox_irq`

## Requirements
- R1: After reset every mailbox, status bit and enable bit reads zero at every offset of both ports, and `l_irq`, `msi_pulse` and `leg_req` are low.
- R2: A host write at offset n (0 to 7) stores its data in host-to-local mailbox n. The value reads back at offset n from both ports. A local write to offsets 0 to 7 changes nothing.
- R3: A local write at offset 8+n stores its data in local-to-host mailbox n. The value reads back at offset 8+n from both ports. A host write to offsets 8 to 15 changes nothing, including the host status.
- R4: A host write to mailbox n sets bit 16+n of the local status register at local offset 16. A local write to offset 16 clears each of bits 23:16 that carries a one and leaves the bits written with zero unchanged. A host write to host offset 16 does not touch the local status register.
- R5: A local write to mailbox 8+n sets bit 16+n of the host status register at host offset 16. A host write of a one to that bit clears it.
- R6: Bits 15:0 of the status register at offset 16 on both ports read the present level of `irq_lines`, and writes to offset 16 do not alter them.
- R7: The enable register is at offset 17 on each port. The local enable keeps only bits 23:16, so an all-ones write reads back as 0x00FF0000. The host enable keeps bits 23:0, so the same write reads back as 0x00FFFFFF. `l_irq` is high exactly when some local status bit is set and enabled.
- R8: If a mailbox write and a one-to-clear of the same status bit occur in the same cycle, the bit ends up set.
- R9: With `msg_en` high, `msi_pulse` is high for exactly one cycle, in the cycle after the host interrupt condition goes from false to true. A new doorbell that arrives while the condition is already true gives no pulse.
- R10: With `msg_en` low and `intx_dis` low, `leg_req` follows the host interrupt condition one cycle later. With either `msg_en` or `intx_dis` high, `leg_req` falls and does not rise.
- R11: After `leg_req` changes it holds its value until `leg_ack` has been seen high, even if the interrupt condition changes in the meantime.
- R12: With `msg_en` low and `intx_dis` high, neither `msi_pulse` nor `leg_req` is asserted for any doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host-side write enable |
| h_addr | input | 5 | Host-side word offset |
| h_wdata | input | 32 | Host-side write data |
| h_rdata | output | 32 | Host-side read data |
| l_we | input | 1 | Local-side write enable |
| l_addr | input | 5 | Local-side word offset |
| l_wdata | input | 32 | Local-side write data |
| l_rdata | output | 32 | Local-side read data |
| irq_lines | input | 16 | Local interrupt input levels |
| msg_en | input | 1 | Message interrupt mode enable |
| intx_dis | input | 1 | Command-register legacy interrupt disable |
| leg_ack | input | 1 | Link acknowledge of a legacy request change |
| l_irq | output | 1 | Interrupt toward the local side |
| msi_pulse | output | 1 | Message interrupt pulse toward the link |
| leg_req | output | 1 | Legacy interrupt request level toward the link |

## Verification
The bench drives a mailbox write and a one-to-clear of the same bit in the same cycle. A design that gives clear priority would lose that doorbell. It writes to mailboxes from the side that does not own them, so a design that decodes writes per offset rather than per side would corrupt data or raise stray doorbells. It holds back the legacy acknowledge while the interrupt condition falls, which exposes a design that drops the request without waiting for the handshake. It also checks that a second doorbell under an already-true condition gives no extra message pulse, and that the interrupt-disable input pulls the request down at once and keeps it down.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

   typedef enum logic {
      LG_IDLE = 1'b0,
      LG_WAIT = 1'b1
   } leg_state_e;

   // status register sits right after both mailbox banks
   function automatic int stat_ofs(input int num_mbox);
      return 2 * num_mbox;
   endfunction

   function automatic int en_ofs(input int num_mbox);
      return 2 * num_mbox + 1;
   endfunction

endpackage

// File: rtl/bmb_mbox_bank.sv
module bmb_mbox_bank #(
   parameter int NUM  = 8,
   parameter int DW   = 32,
   parameter int AW   = 5,
   parameter int BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [NUM-1:0]    hit,
   output logic [NUM*DW-1:0] q
);

   for (genvar i = 0; i < NUM; i++) begin : g_ent
      assign hit[i] = we && (addr == AW'(BASE + i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q[i*DW +: DW] <= '0;
         end else if (hit[i]) begin
            q[i*DW +: DW] <= wdata;
         end
      end
   end

endmodule

// File: rtl/bmb_doorbell.sv
module bmb_doorbell #(
   parameter int NUM     = 8,
   parameter int LW      = 16,
   parameter bit LINE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    set,
   input  logic              clr_we,
   input  logic [NUM-1:0]    clr,
   input  logic              en_we,
   input  logic [LW+NUM-1:0] en_wdata,
   input  logic [LW-1:0]     lines,
   output logic [NUM-1:0]    db,
   output logic [LW+NUM-1:0] en,
   output logic              irq
);

   localparam int TW = LW + NUM;
   localparam logic [TW-1:0] EN_MASK =
      LINE_EN ? {TW{1'b1}} : {{NUM{1'b1}}, {LW{1'b0}}};

   logic [NUM-1:0] clr_eff;

   assign clr_eff = clr_we ? clr : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         db <= '0;
         en <= '0;
      end else begin
         db <= (db & ~clr_eff) | set;
         if (en_we) begin
            en <= en_wdata & EN_MASK;
         end
      end
   end

   assign irq = |({db, lines} & en);

endmodule

// File: rtl/bmb_link_irq.sv
module bmb_link_irq #(
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_lvl,
   input  logic msg_en,
   input  logic intx_dis,
   input  logic leg_ack,
   output logic msi_pulse,
   output logic leg_req
);

   import bmb_pkg::*;

   logic irq_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_d     <= 1'b0;
         msi_pulse <= 1'b0;
      end else begin
         irq_d     <= irq_lvl;
         msi_pulse <= msg_en & irq_lvl & ~irq_d;
      end
   end

   if (LEGACY_EN) begin : g_leg
      leg_state_e st;
      logic       want;

      assign want = irq_lvl & ~msg_en & ~intx_dis;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st      <= LG_IDLE;
            leg_req <= 1'b0;
         end else if (st == LG_IDLE) begin
            if (want != leg_req) begin
               leg_req <= want;
               st      <= LG_WAIT;
            end
         end else if (leg_ack) begin
            st <= LG_IDLE;
         end
      end
   end else begin : g_noleg
      assign leg_req = 1'b0;
   end

endmodule

// File: rtl/bmb_mailbox_irq.sv
module bmb_mailbox_irq #(
   parameter int NUM_MBOX  = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int LINE_W    = 16,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic [LINE_W-1:0] irq_lines,
   input  logic              msg_en,
   input  logic              intx_dis,
   input  logic              leg_ack,
   output logic              l_irq,
   output logic              msi_pulse,
   output logic              leg_req
);

   localparam int OFS_STAT = bmb_pkg::stat_ofs(NUM_MBOX);
   localparam int OFS_EN   = bmb_pkg::en_ofs(NUM_MBOX);
   localparam int TW       = LINE_W + NUM_MBOX;

   if (TW > DATA_W) begin : g_bad_width
      $error("status field does not fit in the data width");
   end
   if (OFS_EN >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register map does not fit in the address width");
   end

   logic [NUM_MBOX-1:0]        h2l_hit, l2h_hit;
   logic [NUM_MBOX*DATA_W-1:0] h2l_q, l2h_q;
   logic [NUM_MBOX-1:0]        l_db, h_db;
   logic [TW-1:0]              l_en, h_en;
   logic                       h_stat_we, h_en_we, l_stat_we, l_en_we;
   logic                       h_irq;

   assign h_stat_we = h_we && (h_addr == ADDR_W'(OFS_STAT));
   assign h_en_we   = h_we && (h_addr == ADDR_W'(OFS_EN));
   assign l_stat_we = l_we && (l_addr == ADDR_W'(OFS_STAT));
   assign l_en_we   = l_we && (l_addr == ADDR_W'(OFS_EN));

   bmb_mbox_bank #(.NUM(NUM_MBOX), .DW(DATA_W), .AW(ADDR_W), .BASE(0)) u_h2l (
      .clk(clk), .rst_n(rst_n), .we(h_we), .addr(h_addr), .wdata(h_wdata),
      .hit(h2l_hit), .q(h2l_q)
   );

   bmb_mbox_bank #(.NUM(NUM_MBOX), .DW(DATA_W), .AW(ADDR_W), .BASE(NUM_MBOX)) u_l2h (
      .clk(clk), .rst_n(rst_n), .we(l_we), .addr(l_addr), .wdata(l_wdata),
      .hit(l2h_hit), .q(l2h_q)
   );

   bmb_doorbell #(.NUM(NUM_MBOX), .LW(LINE_W), .LINE_EN(1'b0)) u_ldb (
      .clk(clk), .rst_n(rst_n), .set(h2l_hit),
      .clr_we(l_stat_we), .clr(l_wdata[LINE_W +: NUM_MBOX]),
      .en_we(l_en_we), .en_wdata(l_wdata[TW-1:0]),
      .lines(irq_lines), .db(l_db), .en(l_en), .irq(l_irq)
   );

   bmb_doorbell #(.NUM(NUM_MBOX), .LW(LINE_W), .LINE_EN(1'b1)) u_hdb (
      .clk(clk), .rst_n(rst_n), .set(l2h_hit),
      .clr_we(h_stat_we), .clr(h_wdata[LINE_W +: NUM_MBOX]),
      .en_we(h_en_we), .en_wdata(h_wdata[TW-1:0]),
      .lines(irq_lines), .db(h_db), .en(h_en), .irq(h_irq)
   );

   bmb_link_irq #(.LEGACY_EN(LEGACY_EN)) u_link (
      .clk(clk), .rst_n(rst_n), .irq_lvl(h_irq), .msg_en(msg_en),
      .intx_dis(intx_dis), .leg_ack(leg_ack),
      .msi_pulse(msi_pulse), .leg_req(leg_req)
   );

   always_comb begin
      h_rdata = '0;
      l_rdata = '0;
      for (int i = 0; i < NUM_MBOX; i++) begin
         if (h_addr == ADDR_W'(i))            h_rdata = h2l_q[i*DATA_W +: DATA_W];
         if (h_addr == ADDR_W'(NUM_MBOX + i)) h_rdata = l2h_q[i*DATA_W +: DATA_W];
         if (l_addr == ADDR_W'(i))            l_rdata = h2l_q[i*DATA_W +: DATA_W];
         if (l_addr == ADDR_W'(NUM_MBOX + i)) l_rdata = l2h_q[i*DATA_W +: DATA_W];
      end
      if (h_addr == ADDR_W'(OFS_STAT)) h_rdata = DATA_W'({h_db, irq_lines});
      if (h_addr == ADDR_W'(OFS_EN))   h_rdata = DATA_W'(h_en);
      if (l_addr == ADDR_W'(OFS_STAT)) l_rdata = DATA_W'({l_db, irq_lines});
      if (l_addr == ADDR_W'(OFS_EN))   l_rdata = DATA_W'(l_en);
   end

endmodule

// File: rtl/bmb_checker.sv
module bmb_checker #(
   parameter int NUM = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NUM-1:0] h2l_hit,
   input logic [NUM-1:0] l2h_hit,
   input logic [NUM-1:0] l_db,
   input logic [NUM-1:0] h_db,
   input logic           msg_en,
   input logic           intx_dis,
   input logic           leg_ack,
   input logic           msi_pulse,
   input logic           leg_req,
   input logic           l_irq
);

   logic req_prev, out_q, outstanding;

   assign outstanding = (leg_req != req_prev) | out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_prev <= 1'b0;
         out_q    <= 1'b0;
      end else begin
         req_prev <= leg_req;
         out_q    <= outstanding & ~leg_ack;
      end
   end

   // R8: a doorbell set survives a same-cycle clear
   a_r8_set_wins_local: assert property (@(posedge clk) disable iff (!rst_n)
      (|h2l_hit) |=> ((l_db & $past(h2l_hit)) == $past(h2l_hit)));

   a_r8_set_wins_host: assert property (@(posedge clk) disable iff (!rst_n)
      (|l2h_hit) |=> ((h_db & $past(l2h_hit)) == $past(l2h_hit)));

   a_r7_local_irq_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (l_db == '0) |-> !l_irq);

   a_r9_msi_single: assert property (@(posedge clk) disable iff (!rst_n)
      msi_pulse |=> !msi_pulse);

   a_r9_msi_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_en |=> !msi_pulse);

   a_r10_leg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ((msg_en || intx_dis) && !leg_req) |=> !leg_req);

   a_r11_leg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding && !leg_ack) |=> $stable(leg_req));

   a_r12_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_en && intx_dis && !leg_req) |=> (!msi_pulse && !leg_req));

endmodule

bind bmb_mailbox_irq bmb_checker #(.NUM(NUM_MBOX)) u_chk (
   .clk(clk), .rst_n(rst_n), .h2l_hit(h2l_hit), .l2h_hit(l2h_hit),
   .l_db(l_db), .h_db(h_db), .msg_en(msg_en), .intx_dis(intx_dis),
   .leg_ack(leg_ack), .msi_pulse(msi_pulse), .leg_req(leg_req), .l_irq(l_irq)
);

// File: tb/bmb_mailbox_irq_bench.sv
`timescale 1ns/1ps
module bmb_mailbox_irq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_we = 1'b0, l_we = 1'b0;
   logic [4:0]  h_addr = '0, l_addr = '0;
   logic [31:0] h_wdata = '0, l_wdata = '0;
   logic [31:0] h_rdata, l_rdata;
   logic [15:0] irq_lines = '0;
   logic        msg_en = 1'b0, intx_dis = 1'b1, leg_ack = 1'b0;
   logic        l_irq, msi_pulse, leg_req;

   int checks = 0;
   int errors = 0;
   bit ack_auto = 1'b1;
   logic seen_req = 1'b0;

   always #2 clk = ~clk;

   bmb_mailbox_irq u_bmb_mailbox_irq (
      .clk(clk), .rst_n(rst_n),
      .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .irq_lines(irq_lines), .msg_en(msg_en), .intx_dis(intx_dis),
      .leg_ack(leg_ack), .l_irq(l_irq), .msi_pulse(msi_pulse), .leg_req(leg_req)
   );

   // link model: acknowledge each request change one cycle later
   always @(negedge clk) begin
      if (ack_auto) begin
         leg_ack = (leg_req !== seen_req);
         seen_req = leg_req;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hwr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); h_we = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk); h_we = 1'b0;
   endtask

   task automatic lwr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); l_we = 1'b1; l_addr = a; l_wdata = d;
      @(negedge clk); l_we = 1'b0;
   endtask

   task automatic hrd(input logic [4:0] a, output logic [31:0] d);
      h_addr = a; #1 d = h_rdata;
   endtask

   task automatic lrd(input logic [4:0] a, output logic [31:0] d);
      l_addr = a; #1 d = l_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 18; a++) begin
         hrd(a[4:0], d); chk("R1 host reg zero", d, 32'h0);
         lrd(a[4:0], d); chk("R1 local reg zero", d, 32'h0);
      end
      chk("R1 l_irq low", {31'b0, l_irq}, 32'h0);
      chk("R1 msi low", {31'b0, msi_pulse}, 32'h0);
      chk("R1 leg_req low", {31'b0, leg_req}, 32'h0);
   endtask

   task automatic t_h2l();
      logic [31:0] d;
      hwr(5'd0, 32'h1111_2222);
      hwr(5'd7, 32'hDEAD_BEEF);
      hrd(5'd0, d); chk("R2 host read mbox0", d, 32'h1111_2222);
      lrd(5'd0, d); chk("R2 local read mbox0", d, 32'h1111_2222);
      lrd(5'd7, d); chk("R2 local read mbox7", d, 32'hDEAD_BEEF);
      lwr(5'd0, 32'h5555_AAAA);
      hrd(5'd0, d); chk("R2 local write ignored", d, 32'h1111_2222);
      lrd(5'd16, d); chk("R4 local status bits", d, 32'h0081_0000);
      hrd(5'd16, d); chk("R4 host status untouched", d, 32'h0);
      lwr(5'd17, 32'h0001_0000);
      chk("R7 l_irq enabled bit", {31'b0, l_irq}, 32'h1);
      lwr(5'd16, 32'h0001_0000);
      lrd(5'd16, d); chk("R4 clear one bit", d, 32'h0080_0000);
      chk("R7 l_irq disabled bit", {31'b0, l_irq}, 32'h0);
      lwr(5'd16, 32'h0);
      lrd(5'd16, d); chk("R4 zero write keeps", d, 32'h0080_0000);
      hwr(5'd2, 32'h0000_0002);
      hwr(5'd16, 32'hFFFF_FFFF);
      lrd(5'd16, d); chk("R4 host clear no effect", d, 32'h0084_0000);
      lwr(5'd16, 32'h00FF_0000);
      lrd(5'd16, d); chk("R4 all cleared", d, 32'h0);
      lwr(5'd17, 32'h0);
   endtask

   task automatic t_l2h();
      logic [31:0] d;
      lwr(5'd9, 32'hCAFE_0009);
      hrd(5'd9, d); chk("R3 host read mbox9", d, 32'hCAFE_0009);
      lrd(5'd9, d); chk("R3 local read mbox9", d, 32'hCAFE_0009);
      hrd(5'd16, d); chk("R5 host status set", d, 32'h0002_0000);
      hwr(5'd9, 32'h1234_5678);
      lrd(5'd9, d); chk("R3 host write ignored", d, 32'hCAFE_0009);
      hwr(5'd16, 32'h0002_0000);
      hrd(5'd16, d); chk("R5 host clear", d, 32'h0);
   endtask

   task automatic t_lines();
      logic [31:0] d;
      irq_lines = 16'hA5C3;
      #1;
      hrd(5'd16, d); chk("R6 host line levels", d, 32'h0000_A5C3);
      lrd(5'd16, d); chk("R6 local line levels", d, 32'h0000_A5C3);
      hwr(5'd16, 32'h0000_FFFF);
      lwr(5'd16, 32'h0000_FFFF);
      hrd(5'd16, d); chk("R6 host write no effect", d, 32'h0000_A5C3);
      irq_lines = 16'h0;
      #1;
      lrd(5'd16, d); chk("R6 local follows level", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      lwr(5'd17, 32'hFFFF_FFFF);
      lrd(5'd17, d); chk("R7 local enable bits", d, 32'h00FF_0000);
      hwr(5'd17, 32'hFFFF_FFFF);
      hrd(5'd17, d); chk("R7 host enable bits", d, 32'h00FF_FFFF);
      hwr(5'd17, 32'h0);
      lwr(5'd17, 32'h0);
      lrd(5'd17, d); chk("R7 local enable cleared", d, 32'h0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      hwr(5'd3, 32'h3);
      @(negedge clk);
      h_we = 1'b1; h_addr = 5'd3; h_wdata = 32'h33;
      l_we = 1'b1; l_addr = 5'd16; l_wdata = 32'h0008_0000;
      @(negedge clk);
      h_we = 1'b0; l_we = 1'b0;
      lrd(5'd16, d); chk("R8 set beats clear", d, 32'h0008_0000);
      lwr(5'd16, 32'h0008_0000);
      lrd(5'd16, d); chk("R8 later clear works", d, 32'h0);
   endtask

   task automatic t_msi();
      msg_en = 1'b1;
      hwr(5'd17, 32'h0003_0000);
      lwr(5'd8, 32'h8);
      chk("R9 no pulse yet", {31'b0, msi_pulse}, 32'h0);
      cyc(1); chk("R9 pulse", {31'b0, msi_pulse}, 32'h1);
      cyc(1); chk("R9 pulse one cycle", {31'b0, msi_pulse}, 32'h0);
      lwr(5'd9, 32'h9);
      cyc(1); chk("R9 no repeat pulse", {31'b0, msi_pulse}, 32'h0);
      cyc(1); chk("R9 no repeat pulse 2", {31'b0, msi_pulse}, 32'h0);
      chk("R10 no legacy in msg mode", {31'b0, leg_req}, 32'h0);
      hwr(5'd16, 32'h0003_0000);
      hwr(5'd17, 32'h0);
      msg_en = 1'b0;
   endtask

   task automatic t_legacy();
      intx_dis = 1'b0;
      hwr(5'd17, 32'h0001_0000);
      lwr(5'd8, 32'h1);
      cyc(2); chk("R10 request rises", {31'b0, leg_req}, 32'h1);
      intx_dis = 1'b1;
      cyc(3); chk("R10 disable drops", {31'b0, leg_req}, 32'h0);
      cyc(3); chk("R10 disable holds low", {31'b0, leg_req}, 32'h0);
      intx_dis = 1'b0;
      cyc(3); chk("R10 reenabled", {31'b0, leg_req}, 32'h1);
      msg_en = 1'b1;
      cyc(3); chk("R10 msg mode drops", {31'b0, leg_req}, 32'h0);
      msg_en = 1'b0;
      cyc(3); chk("R10 back to legacy", {31'b0, leg_req}, 32'h1);
      hwr(5'd16, 32'h0001_0000);
      cyc(3); chk("R10 follows clear", {31'b0, leg_req}, 32'h0);
      // withhold acknowledge
      cyc(2);
      ack_auto = 1'b0; leg_ack = 1'b0;
      lwr(5'd8, 32'h2);
      cyc(2); chk("R11 request rises", {31'b0, leg_req}, 32'h1);
      hwr(5'd16, 32'h0001_0000);
      cyc(5); chk("R11 held without ack", {31'b0, leg_req}, 32'h1);
      leg_ack = 1'b1;
      cyc(1); leg_ack = 1'b0;
      cyc(2); chk("R11 drops after ack", {31'b0, leg_req}, 32'h0);
      seen_req = 1'b1;
      ack_auto = 1'b1;
      cyc(3);
      hwr(5'd17, 32'h0);
      intx_dis = 1'b1;
   endtask

   task automatic t_all_off();
      bit fired = 1'b0;
      msg_en = 1'b0; intx_dis = 1'b1;
      hwr(5'd17, 32'h0010_0000);
      lwr(5'd12, 32'hC);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (msi_pulse || leg_req) fired = 1'b1;
      end
      chk("R12 nothing signalled", {31'b0, fired}, 32'h0);
      hwr(5'd16, 32'h0010_0000);
      hwr(5'd17, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_h2l();
      t_l2h();
      t_lines();
      t_enable();
      t_set_wins();
      t_msi();
      t_legacy();
      t_all_off();
      cyc(2);
      summary();
      $finish;
   end

endmodule